// File: doc/BRIEF.md
# DAC Soft-Reset and Resync Sequencer

This block sits in front of the digital path of a multichannel audio DAC. It turns a software run/stop control bit into a delayed internal reset for that path. Each delay is counted in sample periods, and the stop latency is deliberately longer than the restart latency. While a stop/restart cycle is in progress the block raises a window flag. That flag doubles as the zero-detect indication.

The block keeps a free-running sample-phase counter that advances on the per-sample strobe. A frame-clock edge can realign this counter, but only while the window flag is high, and only when the edge arrives at a phase other than zero. When a realignment happens, the outgoing samples are forced to zero for a fixed number of sample periods. Samples are also forced to zero while the internal reset is active.

Sample data passes through on a valid/ready stream with no storage. The input-side ready is the output-side ready. The output-side valid is the input-side valid. Back-pressure therefore reaches the upstream source in the same cycle, and a word transfers on the input exactly when it transfers on the output. The block only replaces the data value with zero when a gate is active.

Top module: `dac_rsync_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `sync_win` is 0, `core_rst_n` is 1 and `phase_cnt` is 0. With no zero-forcing active, `out_data` equals `in_data`.
- R2: When `sw_run` is sampled low while the window is closed, `sync_win` is 1 from the next cycle onward.
- R3: `core_rst_n` falls at the clock edge of the FALL_TICKS-th `fs_tick` after the edge at which the stop was sampled (default 3). It only ever falls on a tick, and it is low only while `sync_win` is 1.
- R4: Once `core_rst_n` is low and `sw_run` is sampled high, `core_rst_n` rises at the edge of the RISE_TICKS-th `fs_tick` after that sample (default 2). `sync_win` is still 1 at that point.
- R5: `sync_win` falls at the edge of the TAIL_TICKS-th `fs_tick` after the rise of `core_rst_n` (default 2).
- R6: A `frame_edge` pulse realigns the counter when `sync_win` is 1 and `phase_cnt` is not 0. `phase_cnt` is 0 on the next cycle, and `out_data` is 0 from then until the edge of the ZERO_TICKS-th following `fs_tick` (default 4). After that edge `out_data` follows `in_data` again.
- R7: A `frame_edge` pulse while `sync_win` is 0 is ignored. `phase_cnt` and `out_data` are unchanged by it.
- R8: `phase_cnt` advances by one on every `fs_tick` and wraps from FRAME_LEN-1 to 0. It holds its value when there is no tick.
- R9: While `core_rst_n` is 0, `out_data` is 0, which is the two's-complement midscale code.
- R10: Sampling `sw_run` low during the restart wait or the flag tail restarts the full stop sequence. `sync_win` stays 1 throughout, and the FALL_TICKS count starts again from the new stop.
- R11: `in_ready` equals `out_ready` and `out_valid` equals `in_valid` at all times. When no gate is active, `out_data` equals `in_data` bit for bit.
- R12: A realignment that lands during the stop wait is accepted before `core_rst_n` has fallen. `phase_cnt` becomes 0 in that case too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| sw_run | input | 1 | Software control bit: 1 runs, 0 requests the digital reset |
| frame_edge | input | 1 | One-cycle pulse on a frame-clock edge |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample ready (equals out_ready) |
| in_data | input | DATA_W | Input sample, two's complement |
| out_valid | output | 1 | Output sample valid (equals in_valid) |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output sample, zero when gated |
| sync_win | output | 1 | Zero-detect / resync window flag |
| core_rst_n | output | 1 | Delayed internal reset, active low |
| phase_cnt | output | $clog2(FRAME_LEN) | Internal sample-phase counter |

## Verification
The bench builds the block with DATA_W = 8 and FRAME_LEN = 8, and keeps the default latencies of 3, 2, 2 and 4 sample periods. The 8-bit data width lets every input code be swept against every valid/ready combination. The 8-entry frame keeps the counter wrap, a misaligned frame edge and a restart of the zero-force count within a few dozen ticks. Because the bench drives the sample strobe itself, it can place the realignment edge, the mid-sequence rewrites of the control bit and each latency boundary on an exact tick. The expected counter phase is tracked arithmetically in the bench.

// File: rtl/dac_rsync_pkg.sv
`timescale 1ns/1ps
package dac_rsync_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,  // normal operation, window closed
    ST_FALL = 3'd1,  // stop written, waiting to assert core reset
    ST_HELD = 3'd2,  // core reset asserted
    ST_RISE = 3'd3,  // run written back, waiting to release core reset
    ST_TAIL = 3'd4   // core reset released, window still open
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rsync_seq_ctrl.sv
`timescale 1ns/1ps
module rsync_seq_ctrl
  import dac_rsync_pkg::*;
#(
  parameter int FALL_TICKS = 3,
  parameter int RISE_TICKS = 2,
  parameter int TAIL_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_tick,
  input  logic sw_run,
  output logic sync_win,
  output logic core_rst_n
);

  localparam int MAXT = max3(FALL_TICKS, RISE_TICKS, TAIL_TICKS);
  localparam int CW   = (MAXT < 2) ? 1 : $clog2(MAXT);

  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_TICKS - 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_TICKS - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_TICKS - 1);

  seq_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic            win_q;
  logic            crst_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      cnt_q    <= '0;
      win_q    <= 1'b0;
      crst_n_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (!sw_run) begin
            state_q <= ST_FALL;
            cnt_q   <= '0;
            win_q   <= 1'b1;
          end
        end
        ST_FALL: begin
          if (fs_tick) begin
            if (cnt_q == FALL_LAST) begin
              crst_n_q <= 1'b0;
              state_q  <= ST_HELD;
              cnt_q    <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_HELD: begin
          if (sw_run) begin
            state_q <= ST_RISE;
            cnt_q   <= '0;
          end
        end
        ST_RISE: begin
          if (!sw_run) begin
            state_q <= ST_FALL;
            cnt_q   <= '0;
          end else if (fs_tick) begin
            if (cnt_q == RISE_LAST) begin
              crst_n_q <= 1'b1;
              state_q  <= ST_TAIL;
              cnt_q    <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (!sw_run) begin
            state_q <= ST_FALL;
            cnt_q   <= '0;
          end else if (fs_tick) begin
            if (cnt_q == TAIL_LAST) begin
              win_q   <= 1'b0;
              state_q <= ST_RUN;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          state_q  <= ST_RUN;
          cnt_q    <= '0;
          win_q    <= 1'b0;
          crst_n_q <= 1'b1;
        end
      endcase
    end
  end

  assign sync_win   = win_q;
  assign core_rst_n = crst_n_q;

endmodule

// File: rtl/rsync_phase_track.sv
`timescale 1ns/1ps
module rsync_phase_track #(
  parameter int FRAME_LEN  = 64,
  parameter int ZERO_TICKS = 4,
  localparam int PW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          frame_edge,
  input  logic          sync_win,
  output logic [PW-1:0] phase_cnt,
  output logic          force_zero
);

  localparam bit POW2 = ((FRAME_LEN & (FRAME_LEN - 1)) == 0);
  localparam int ZW   = (ZERO_TICKS < 2) ? 1 : $clog2(ZERO_TICKS);
  localparam logic [ZW-1:0] ZERO_LAST = ZW'(ZERO_TICKS - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;
  logic          realign;
  logic          zf_q;
  logic [ZW-1:0] zc_q;

  generate
    if (POW2) begin : g_wrap_pow2
      assign phase_nxt = phase_q + 1'b1;
    end else begin : g_wrap_cmp
      assign phase_nxt = (phase_q == PW'(FRAME_LEN - 1)) ? '0 : phase_q + 1'b1;
    end
  endgenerate

  // A frame edge only matters inside the window and off the zero phase.
  assign realign = frame_edge && sync_win && (phase_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (realign) begin
      phase_q <= '0;
    end else if (fs_tick) begin
      phase_q <= phase_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zf_q <= 1'b0;
      zc_q <= '0;
    end else if (realign) begin
      zf_q <= 1'b1;
      zc_q <= '0;
    end else if (zf_q && fs_tick) begin
      if (zc_q == ZERO_LAST) begin
        zf_q <= 1'b0;
        zc_q <= '0;
      end else begin
        zc_q <= zc_q + 1'b1;
      end
    end
  end

  assign phase_cnt  = phase_q;
  assign force_zero = zf_q;

endmodule

// File: rtl/rsync_data_gate.sv
`timescale 1ns/1ps
module rsync_data_gate #(
  parameter int DATA_W = 24
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              force_zero,
  input  logic              core_rst_n
);

  logic gate;

  assign gate      = force_zero || !core_rst_n;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_data  = gate ? '0 : in_data;

endmodule

// File: rtl/dac_rsync_seq.sv
`timescale 1ns/1ps
module dac_rsync_seq #(
  parameter int DATA_W     = 24,
  parameter int FRAME_LEN  = 64,
  parameter int FALL_TICKS = 3,
  parameter int RISE_TICKS = 2,
  parameter int TAIL_TICKS = 2,
  parameter int ZERO_TICKS = 4,
  localparam int PW = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_tick,
  input  logic              sw_run,
  input  logic              frame_edge,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              sync_win,
  output logic              core_rst_n,
  output logic [PW-1:0]     phase_cnt
);

  logic force_zero;

  rsync_seq_ctrl #(
    .FALL_TICKS (FALL_TICKS),
    .RISE_TICKS (RISE_TICKS),
    .TAIL_TICKS (TAIL_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_tick    (fs_tick),
    .sw_run     (sw_run),
    .sync_win   (sync_win),
    .core_rst_n (core_rst_n)
  );

  rsync_phase_track #(
    .FRAME_LEN  (FRAME_LEN),
    .ZERO_TICKS (ZERO_TICKS)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_tick    (fs_tick),
    .frame_edge (frame_edge),
    .sync_win   (sync_win),
    .phase_cnt  (phase_cnt),
    .force_zero (force_zero)
  );

  rsync_data_gate #(
    .DATA_W (DATA_W)
  ) u_gate (
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .force_zero (force_zero),
    .core_rst_n (core_rst_n)
  );

endmodule

// File: rtl/dac_rsync_chk.sv
`timescale 1ns/1ps
module dac_rsync_chk #(
  parameter int DATA_W    = 24,
  parameter int FRAME_LEN = 64,
  localparam int PW = $clog2(FRAME_LEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_tick,
  input logic              sw_run,
  input logic              frame_edge,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              sync_win,
  input logic              core_rst_n,
  input logic [PW-1:0]     phase_cnt
);

  p_win_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_run && !sync_win) |=> sync_win);

  p_rst_in_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> sync_win);

  p_fall_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_n) |-> $past(fs_tick));

  p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> ($past(fs_tick) && $past(sw_run)));

  p_realign_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_edge && sync_win && phase_cnt != '0) |=> (phase_cnt == '0 && out_data == '0));

  p_ignore_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_edge && !sync_win && !fs_tick) |=> $stable(phase_cnt));

  p_phase_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_tick && !(frame_edge && sync_win && phase_cnt != '0))
      |=> int'(phase_cnt) == (int'($past(phase_cnt)) + 1) % FRAME_LEN);

  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_tick && !frame_edge) |=> $stable(phase_cnt));

  p_zero_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> out_data == '0);

  p_flow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

endmodule

bind dac_rsync_seq dac_rsync_chk #(
  .DATA_W    (DATA_W),
  .FRAME_LEN (FRAME_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fs_tick    (fs_tick),
  .sw_run     (sw_run),
  .frame_edge (frame_edge),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .sync_win   (sync_win),
  .core_rst_n (core_rst_n),
  .phase_cnt  (phase_cnt)
);

// File: tb/tb_dac_rsync_seq.sv
`timescale 1ns/1ps
module tb_dac_rsync_seq;

  localparam int DW = 8;
  localparam int FL = 8;
  localparam int PW = $clog2(FL);
  localparam logic [DW-1:0] PAT = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n, fs_tick, sw_run, frame_edge;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] in_data, out_data;
  logic          sync_win, core_rst_n;
  logic [PW-1:0] phase_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_phase = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_rsync_seq #(.DATA_W(DW), .FRAME_LEN(FL)) dut (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .sw_run(sw_run),
    .frame_edge(frame_edge), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .sync_win(sync_win), .core_rst_n(core_rst_n),
    .phase_cnt(phase_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    fs_tick = 1'b1;
    cyc();
    fs_tick = 1'b0;
    exp_phase = (exp_phase + 1) % FL;
  endtask

  task automatic edge_pulse(input bit realigns);
    frame_edge = 1'b1;
    cyc();
    frame_edge = 1'b0;
    if (realigns) exp_phase = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fs_tick = 1'b0; sw_run = 1'b1; frame_edge = 1'b0;
    in_valid = 1'b1; out_ready = 1'b1; in_data = PAT;
    @(negedge clk);
    repeat (3) cyc();
    // R1 reset state
    chk("R1 sync_win", sync_win, 0);
    chk("R1 core_rst_n", core_rst_n, 1);
    chk("R1 phase_cnt", phase_cnt, 0);
    chk("R1 out_data", out_data, PAT);
    rst_n = 1'b1;
    cyc();
    chk("R1 sync_win after release", sync_win, 0);

    // R8 counter sweep through more than two wraps
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R8 phase step", phase_cnt, exp_phase);
    end
    repeat (3) cyc();
    chk("R8 hold without tick", phase_cnt, exp_phase);

    // R11 exhaustive data and handshake sweep
    for (int v = 0; v < 256; v++) begin
      for (int hs = 0; hs < 4; hs++) begin
        in_data = v[DW-1:0]; in_valid = hs[0]; out_ready = hs[1];
        #0.5;
        chk("R11 data", out_data, v);
        chk("R11 valid", out_valid, hs[0]);
        chk("R11 ready", in_ready, hs[1]);
      end
    end
    in_data = PAT; in_valid = 1'b1; out_ready = 1'b1;

    // R7 frame edge ignored with window closed (phase is 4)
    edge_pulse(1'b0);
    chk("R7 phase unchanged", phase_cnt, exp_phase);
    chk("R7 data unchanged", out_data, PAT);

    // R2 / R3 / R12 stop sequence with an early realignment
    sw_run = 1'b0;
    cyc();
    chk("R2 window opens", sync_win, 1);
    chk("R3 core still running", core_rst_n, 1);
    tick();
    chk("R3 after 1 tick", core_rst_n, 1);
    edge_pulse(1'b1);
    chk("R12 realign before reset", phase_cnt, 0);
    tick();
    chk("R3 after 2 ticks", core_rst_n, 1);
    tick();
    chk("R3 after 3 ticks", core_rst_n, 0);
    chk("R9 data zero in reset", out_data, 0);

    repeat (5) tick();
    chk("R8 phase during reset", phase_cnt, exp_phase);
    chk("R9 data still zero", out_data, 0);

    // R4 restart latency
    sw_run = 1'b1;
    cyc();
    tick();
    chk("R4 after 1 tick", core_rst_n, 0);
    tick();
    chk("R4 after 2 ticks", core_rst_n, 1);
    chk("R4 window still open", sync_win, 1);

    // R6 realignment in the tail, R5 window close
    chk("R6 precondition phase", (exp_phase != 0) ? 1 : 0, 1);
    edge_pulse(1'b1);
    chk("R6 phase zero", phase_cnt, 0);
    chk("R6 data forced", out_data, 0);
    tick();
    chk("R5 window after 1 tick", sync_win, 1);
    chk("R6 forced tick 1", out_data, 0);
    tick();
    chk("R5 window closed", sync_win, 0);
    chk("R6 forced tick 2", out_data, 0);
    tick();
    chk("R6 forced tick 3", out_data, 0);
    tick();
    chk("R6 released tick 4", out_data, PAT);
    chk("R8 phase after realign", phase_cnt, exp_phase);

    // R10 stop rewritten during restart wait
    sw_run = 1'b0;
    cyc();
    repeat (3) tick();
    chk("R3 second stop", core_rst_n, 0);
    sw_run = 1'b1;
    cyc();
    tick();
    sw_run = 1'b0;
    cyc();
    chk("R10 window held", sync_win, 1);
    chk("R10 core held", core_rst_n, 0);
    tick();
    tick();
    sw_run = 1'b1;
    chk("R10 still in reset", core_rst_n, 0);
    tick();
    cyc();
    tick();
    chk("R10 restart wait 1", core_rst_n, 0);
    tick();
    chk("R10 released", core_rst_n, 1);

    // R10 stop rewritten during flag tail
    tick();
    sw_run = 1'b0;
    cyc();
    chk("R10 tail window held", sync_win, 1);
    tick();
    tick();
    chk("R10 tail recount 2", core_rst_n, 1);
    chk("R10 tail window still", sync_win, 1);
    tick();
    chk("R10 tail recount 3", core_rst_n, 0);
    sw_run = 1'b1;
    cyc();
    tick();
    tick();
    chk("R4 final release", core_rst_n, 1);
    tick();
    tick();
    chk("R5 final close", sync_win, 0);
    chk("R8 final phase", phase_cnt, exp_phase);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule